// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block moves outgoing packets from system memory to a line-side stream. It has four fixed transmit slots. Each slot is a pair of 32-bit registers: a buffer base address and a command/status word. Software fills in the base address. It then writes the byte count and a start threshold into the command word with the ownership bit cleared, which hands the slot to the engine.

The engine visits the slots in a fixed rotation. It waits at the current slot until that slot is handed over. It then reads the buffer word by word through a simple request/acknowledge memory port into an internal FIFO. Once the FIFO holds enough words, it streams them out on a valid/ready line interface. After the last word leaves, the engine writes the result back into the slot. That result carries the collision count and heartbeat reported by the MAC, a completion flag and ownership returned to software. The engine also raises a level interrupt that stays high until software acknowledges it. Every finished slot keeps its status, so several completions can be serviced by one interrupt.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset every command word reads 0x0000_2000 (ownership bit 13 set: software owns the slot), every base address reads 0, and `tok_irq`, `mem_req` and `line_valid` are low.
- R2: Register map on `host_addr`: command word of slot k at byte offset 4k (0x00..0x0C), base address of slot k at 0x10+4k. Only the fields size [12:0], ownership [13] and threshold [21:16] are writable; the other bits read back as 0 after a host write. Accesses with `host_addr[1:0]` not zero are ignored.
- R3: Slots are served strictly in the order 0,1,2,3,0,... The engine waits at the current slot while its bit 13 is 1 and does not skip ahead to a later slot that is handed over.
- R4: For a slot of N bytes the engine reads words at base, base+4, ... for ceil(N/4) words and delivers them on the line in the same order, with `line_last` high only on the final word.
- R5: In each packet, `line_valid` stays low until the FIFO holds at least the threshold (bits [21:16], in words), or every word is fetched, or the FIFO is full.
- R6: On completion the command word keeps size and threshold, sets bit 13 (ownership back to software) and bit 14 (transmit OK), and loads bits [27:24] with `mac_col_cnt`.
- R7: On completion bit 28 takes `mac_heartbeat`, but is written 0 when `link_fast` is high.
- R8: A slot handed over with size 0 completes with no memory read and no line word, and gets the same status writeback.
- R9: Each completion sets `tok_irq`. It stays high until `tok_ack`, and the status of all finished slots stays readable.
- R10: A host write to the registers of the slot in service is ignored.
- R11: A host write to a command word clears bits 14, 24..28 of that slot.
- R12: `mem_req` is never high while the FIFO is full. With the line stalled, exactly FIFO_DEPTH words are fetched and then fetching waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on address) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory acknowledge; data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| line_valid | output | 1 | Line word valid |
| line_data | output | 32 | Line word |
| line_last | output | 1 | Final word of packet |
| line_ready | input | 1 | Line accepts word |
| mac_col_cnt | input | 4 | Collision count for the current packet |
| mac_heartbeat | input | 1 | Carrier-detect heartbeat seen |
| link_fast | input | 1 | High-speed link mode (heartbeat forced to 0) |
| tok_irq | output | 1 | Transmit-OK interrupt, level |
| tok_ack | input | 1 | Clears `tok_irq` |

## Verification
A wrong slot pointer shows at the memory port within one cycle of a handover. The first request then goes to the wrong base, or no request comes at all while a slot waits. A wrong fetch or send count shows as a wrong address or a misplaced `line_last` on the very next word. A start gate that opens early shows as `line_valid` before the threshold count of acknowledges. A bad writeback is visible in the command word one cycle after the last word is accepted.

// File: rtl/txd_pkg.sv
// Package: shared constants and types of the transmit descriptor engine.
// Assumes: a 32-bit host register width and four slots.
package txd_pkg;
    localparam int SLOTS   = 4;
    localparam int SLOT_W  = 2;
    localparam int SIZE_W  = 13;
    localparam int THR_W   = 6;
    localparam int CNT_W   = SIZE_W - 1;   // words per packet, up to 2048
    localparam int OWN_B   = 13;
    localparam int TOK_B   = 14;
    localparam int THR_LO  = 16;
    localparam int NCC_LO  = 24;
    localparam int HB_B    = 28;
    localparam logic [31:0] WR_MASK = 32'h003F_3FFF;

    typedef enum logic [1:0] {
        SEQ_WAIT = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/txd_word_fifo.sv
// Module: txd_word_fifo
// Synchronous word FIFO between the fetch side and the line side.
// Assumes: DEPTH is a power of two; push is never asserted when full.
module txd_word_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign head  = store[rd_ptr];

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // Word storage, written on push.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txd_slot_regs.sv
// Module: txd_slot_regs
// Holds the four base-address / command-word pairs, serves host access and
// applies the completion writeback from the sequencer.
// Assumes: writeback and a host write never target the same slot in one cycle
// (host writes to the slot in service are dropped).
module txd_slot_regs
    import txd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_we,
    input  logic [4:0]                   host_addr,
    input  logic [31:0]                  host_wdata,
    output logic [31:0]                  host_rdata,
    input  logic                         busy,
    input  logic [SLOT_W-1:0]            busy_slot,
    input  logic                         wb_en,
    input  logic [SLOT_W-1:0]            wb_slot,
    input  logic [3:0]                   wb_ncc,
    input  logic                         wb_hb,
    input  logic                         link_fast,
    output logic [SLOTS-1:0]             slot_own,
    output logic [SLOTS-1:0][SIZE_W-1:0] slot_size,
    output logic [SLOTS-1:0][THR_W-1:0]  slot_thr,
    output logic [SLOTS-1:0][31:0]       slot_base
);
    logic [SLOTS-1:0][31:0] stat_q;
    logic [SLOT_W-1:0]      sel;
    logic                   aligned;

    assign sel     = host_addr[3:2];
    assign aligned = (host_addr[1:0] == 2'b00);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic hit;
        assign hit = host_we && aligned && (sel == SLOT_W'(k))
                     && !(busy && (busy_slot == SLOT_W'(k)));

        // Command word: completion writeback or host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[k] <= 32'h0000_2000;
            end else if (wb_en && (wb_slot == SLOT_W'(k))) begin
                stat_q[k][HB_B]               <= wb_hb;
                stat_q[k][NCC_LO+3:NCC_LO]    <= wb_ncc;
                stat_q[k][TOK_B]              <= 1'b1;
                stat_q[k][OWN_B]              <= 1'b1;
            end else if (hit && !host_addr[4]) begin
                stat_q[k] <= host_wdata & WR_MASK;
            end
        end

        // Base address: host write only.
        always_ff @(posedge clk) begin
            if (!rst_n)                    slot_base[k] <= '0;
            else if (hit && host_addr[4])  slot_base[k] <= host_wdata;
        end

        assign slot_own[k]  = stat_q[k][OWN_B];
        assign slot_size[k] = stat_q[k][SIZE_W-1:0];
        assign slot_thr[k]  = stat_q[k][THR_LO+THR_W-1:THR_LO];
    end

    // Host read mux.
    always_comb begin
        if (!aligned)          host_rdata = '0;
        else if (host_addr[4]) host_rdata = slot_base[sel];
        else                   host_rdata = stat_q[sel];
    end

    assert_done_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (stat_q[$past(wb_slot)][OWN_B] && stat_q[$past(wb_slot)][TOK_B]));
    assert_fast_no_hb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && link_fast) |=> !stat_q[$past(wb_slot)][HB_B]);
endmodule

// File: rtl/txd_seq_ctrl.sv
// Module: txd_seq_ctrl
// Walks the slots in rotation, fetches the buffer of a handed-over slot into
// the FIFO, gates the line start on the threshold and issues the writeback.
// Assumes: mem_ack only while mem_req; FIFO depth below 2^16.
module txd_seq_ctrl
    import txd_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int FCW  = $clog2(DEPTH) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SLOTS-1:0]             slot_own,
    input  logic [SLOTS-1:0][SIZE_W-1:0] slot_size,
    input  logic [SLOTS-1:0][THR_W-1:0]  slot_thr,
    input  logic [SLOTS-1:0][31:0]       slot_base,
    input  logic [FCW-1:0]               fifo_cnt,
    input  logic                         fifo_full,
    input  logic                         fifo_empty,
    output logic                         mem_req,
    output logic [31:0]                  mem_addr,
    input  logic                         mem_ack,
    output logic                         push,
    output logic                         line_valid,
    output logic                         line_last,
    input  logic                         line_ready,
    output logic                         pop,
    input  logic [3:0]                   mac_col_cnt,
    input  logic                         mac_heartbeat,
    input  logic                         link_fast,
    output logic                         busy,
    output logic [SLOT_W-1:0]            cur_slot,
    output logic                         wb_en,
    output logic [3:0]                   wb_ncc,
    output logic                         wb_hb,
    input  logic                         tok_ack,
    output logic                         tok_irq
);
    seq_state_t         st;
    logic [SIZE_W-1:0]  size_q;
    logic [THR_W-1:0]   thr_q;
    logic [31:0]        base_q;
    logic [CNT_W-1:0]   total_q, fetch_cnt, send_cnt;
    logic               started;
    logic [SIZE_W:0]    size_p3;
    logic               gate_open;

    assign size_p3   = {1'b0, slot_size[cur_slot]} + (SIZE_W+1)'(3);
    assign gate_open = (16'(fifo_cnt) >= 16'(thr_q)) || (fetch_cnt == total_q) || fifo_full;

    assign mem_req    = (st == SEQ_RUN) && (fetch_cnt != total_q) && !fifo_full;
    assign mem_addr   = base_q + 32'({fetch_cnt, 2'b00});
    assign push       = mem_req && mem_ack;
    assign line_valid = (st == SEQ_RUN) && started && !fifo_empty;
    assign line_last  = (send_cnt == total_q - CNT_W'(1));
    assign pop        = line_valid && line_ready;
    assign busy       = (st != SEQ_WAIT);
    assign wb_en      = (st == SEQ_DONE);
    assign wb_ncc     = mac_col_cnt;
    assign wb_hb      = mac_heartbeat && !link_fast;

    // Slot sequencing, packet counters and start gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SEQ_WAIT;
            cur_slot  <= '0;
            size_q    <= '0;
            thr_q     <= '0;
            base_q    <= '0;
            total_q   <= '0;
            fetch_cnt <= '0;
            send_cnt  <= '0;
            started   <= 1'b0;
        end else begin
            unique case (st)
                SEQ_WAIT: if (!slot_own[cur_slot]) begin
                    size_q    <= slot_size[cur_slot];
                    thr_q     <= slot_thr[cur_slot];
                    base_q    <= slot_base[cur_slot];
                    total_q   <= size_p3[SIZE_W:2];
                    fetch_cnt <= '0;
                    send_cnt  <= '0;
                    started   <= 1'b0;
                    st <= (slot_size[cur_slot] == '0) ? SEQ_DONE : SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (push) fetch_cnt <= fetch_cnt + 1'b1;
                    if (pop)  send_cnt  <= send_cnt + 1'b1;
                    if (!started && gate_open) started <= 1'b1;
                    if (pop && line_last) st <= SEQ_DONE;
                end
                SEQ_DONE: begin
                    cur_slot <= cur_slot + 1'b1;
                    st       <= SEQ_WAIT;
                end
                default: st <= SEQ_WAIT;
            endcase
        end
    end

    // Transmit-OK interrupt: set on completion, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      tok_irq <= 1'b0;
        else if (wb_en)  tok_irq <= 1'b1;
        else if (tok_ack) tok_irq <= 1'b0;
    end

    assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && send_cnt == '0) |->
        (16'(fifo_cnt) >= 16'(thr_q) || fetch_cnt == total_q || fifo_full
         || $past(16'(fifo_cnt) >= 16'(thr_q) || fifo_full)));
    assert_zero_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (size_q != '0));
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (fetch_cnt + CNT_W'(1) != total_q)) |=>
        (!mem_req || mem_addr == $past(mem_addr) + 32'd4));
    assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> tok_irq);
    assert_full_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !mem_req);
endmodule

// File: rtl/tx_desc_engine.sv
// Module: tx_desc_engine (top)
// Four-slot transmit descriptor engine: host registers, sequencer and FIFO.
// Assumes: FIFO_DEPTH is a power of two; memory answers with data in the
// acknowledge cycle.
module tx_desc_engine
    import txd_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [4:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        line_valid,
    output logic [31:0] line_data,
    output logic        line_last,
    input  logic        line_ready,
    input  logic [3:0]  mac_col_cnt,
    input  logic        mac_heartbeat,
    input  logic        link_fast,
    output logic        tok_irq,
    input  logic        tok_ack
);
    localparam int FCW = $clog2(FIFO_DEPTH) + 1;

    logic [SLOTS-1:0]             slot_own;
    logic [SLOTS-1:0][SIZE_W-1:0] slot_size;
    logic [SLOTS-1:0][THR_W-1:0]  slot_thr;
    logic [SLOTS-1:0][31:0]       slot_base;
    logic [FCW-1:0]               fifo_cnt;
    logic                         fifo_full, fifo_empty, push, pop;
    logic                         busy, wb_en, wb_hb;
    logic [SLOT_W-1:0]            cur_slot;
    logic [3:0]                   wb_ncc;

    txd_slot_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy(busy), .busy_slot(cur_slot),
        .wb_en(wb_en), .wb_slot(cur_slot), .wb_ncc(wb_ncc), .wb_hb(wb_hb),
        .link_fast(link_fast),
        .slot_own(slot_own), .slot_size(slot_size), .slot_thr(slot_thr),
        .slot_base(slot_base)
    );

    txd_seq_ctrl #(.DEPTH(FIFO_DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .slot_own(slot_own), .slot_size(slot_size), .slot_thr(slot_thr),
        .slot_base(slot_base),
        .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .push(push),
        .line_valid(line_valid), .line_last(line_last), .line_ready(line_ready),
        .pop(pop),
        .mac_col_cnt(mac_col_cnt), .mac_heartbeat(mac_heartbeat),
        .link_fast(link_fast),
        .busy(busy), .cur_slot(cur_slot),
        .wb_en(wb_en), .wb_ncc(wb_ncc), .wb_hb(wb_hb),
        .tok_ack(tok_ack), .tok_irq(tok_irq)
    );

    txd_word_fifo #(.DEPTH(FIFO_DEPTH), .DW(32)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(mem_rdata), .pop(pop),
        .head(line_data), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !line_valid && !tok_irq));
    assert_rotation_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (cur_slot == $past(cur_slot) + 1'b1));
endmodule

// File: tb/tb_tx_desc_engine.sv
module tb_tx_desc_engine;
    localparam logic [31:0] PAT = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        line_valid, line_last;
    logic [31:0] line_data;
    logic        line_ready = 1'b1;
    logic [3:0]  mac_col_cnt = '0;
    logic        mac_heartbeat = 1'b0;
    logic        link_fast = 1'b0;
    logic        tok_irq;
    logic        tok_ack = 1'b0;
    logic        ack_en = 1'b1;

    int checks = 0, fails = 0;
    logic [31:0] fetch_log [256];
    logic [31:0] line_log  [256];
    logic        last_log  [256];
    int fetch_n = 0, line_n = 0, fv_acks = -1;

    always #10 clk = ~clk;   // 50 MHz

    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = mem_addr ^ PAT;

    tx_desc_engine dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata),
        .line_valid(line_valid), .line_data(line_data), .line_last(line_last),
        .line_ready(line_ready),
        .mac_col_cnt(mac_col_cnt), .mac_heartbeat(mac_heartbeat),
        .link_fast(link_fast), .tok_irq(tok_irq), .tok_ack(tok_ack)
    );

    // Monitor: record transfers that will complete at the next rising edge.
    always @(negedge clk) begin
        if (line_valid && fv_acks < 0) fv_acks = fetch_n;
        if (mem_req && mem_ack && fetch_n < 256) begin
            fetch_log[fetch_n] = mem_addr; fetch_n++;
        end
        if (line_valid && line_ready && line_n < 256) begin
            line_log[line_n] = line_data; last_log[line_n] = line_last; line_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(posedge clk);
        fetch_n = 0; line_n = 0; fv_acks = -1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; #1;
        d = host_rdata;
    endtask

    task automatic wait_done(input int slot);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(5'(slot*4), v);
            if (v[13]) break;
        end
    endtask

    function automatic logic [31:0] done_word(input int size, input int thr,
                                              input int ncc, input bit hb);
        return (32'(hb) << 28) | (32'(ncc) << 24) | (32'(thr) << 16)
               | 32'h0000_6000 | 32'(size);
    endfunction

    task automatic chk_packet(input string req, input logic [31:0] base,
                              input int words, input int f0, input int l0);
        bit ok = 1;
        for (int i = 0; i < words; i++) begin
            if (fetch_log[f0+i] !== base + 32'(4*i)) ok = 0;
            if (line_log[l0+i] !== ((base + 32'(4*i)) ^ PAT)) ok = 0;
            if (last_log[l0+i] !== (i == words-1)) ok = 0;
        end
        chk(req, 32'(ok), 32'd1);
    endtask

    task automatic t_reset();   // R1
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd(5'(4*k), v);        chk("R1 command reset", v, 32'h0000_2000);
            rd(5'(16+4*k), v);     chk("R1 base reset", v, 32'h0);
        end
        chk("R1 outputs idle", {29'd0, tok_irq, mem_req, line_valid}, 32'h0);
    endtask

    task automatic t_regmap();  // R2
        logic [31:0] v;
        for (int k = 0; k < 4; k++) wr(5'(16+4*k), 32'h1000 * (k+1));
        for (int k = 0; k < 4; k++) begin
            rd(5'(16+4*k), v); chk("R2 base readback", v, 32'h1000 * (k+1));
        end
        wr(5'h0C, 32'hFFC0_2005);
        rd(5'h0C, v); chk("R2 writable fields only", v, 32'h0000_2005);
        wr(5'h0D, 32'h0000_0001);
        rd(5'h0C, v); chk("R2 unaligned write ignored", v, 32'h0000_2005);
    endtask

    task automatic t_rotation(); // R3, R4, R6, R9
        logic [31:0] v;
        clear_logs();
        mac_col_cnt = 4'd3; mac_heartbeat = 1'b0; link_fast = 1'b0;
        wr(5'h04, 32'h0000_0008);
        repeat (20) @(negedge clk);
        chk("R3 stall at unowned slot 0", 32'(fetch_n), 32'd0);
        rd(5'h04, v); chk("R3 slot 1 still pending", v, 32'h0000_0008);
        wr(5'h00, 32'h0000_0008);
        wait_done(0); wait_done(1);
        chk("R3 slot0 served first", fetch_log[0], 32'h1000);
        chk_packet("R4 slot0 words", 32'h1000, 2, 0, 0);
        chk_packet("R4 slot1 words", 32'h2000, 2, 2, 2);
        rd(5'h00, v); chk("R6 slot0 writeback", v, done_word(8, 0, 3, 0));
        rd(5'h04, v); chk("R9 slot1 status kept", v, done_word(8, 0, 3, 0));
        chk("R9 irq raised", 32'(tok_irq), 32'd1);
        @(negedge clk); tok_ack = 1'b1; @(negedge clk); tok_ack = 1'b0;
        chk("R9 irq cleared by ack", 32'(tok_irq), 32'd0);
    endtask

    task automatic t_threshold(); // R5, R6, R7
        logic [31:0] v;
        clear_logs();
        mac_col_cnt = 4'd5; mac_heartbeat = 1'b1; link_fast = 1'b0;
        wr(5'h08, 32'h0004_0028);
        wait_done(2);
        chk("R5 threshold 4 reached first", 32'(fv_acks >= 4), 32'd1);
        chk_packet("R4 slot2 words", 32'h3000, 10, 0, 0);
        rd(5'h08, v); chk("R7 heartbeat slow mode", v, done_word(40, 4, 5, 1));
        clear_logs();
        mac_col_cnt = 4'd0; link_fast = 1'b1;
        wr(5'h0C, 32'h003F_0028);
        wait_done(3);
        chk("R5 large threshold waits for all words", 32'(fv_acks), 32'd10);
        rd(5'h0C, v); chk("R7 heartbeat forced 0 fast", v, done_word(40, 63, 0, 0));
        @(negedge clk); tok_ack = 1'b1; @(negedge clk); tok_ack = 1'b0;
    endtask

    task automatic t_zero();    // R8
        logic [31:0] v;
        clear_logs();
        mac_col_cnt = 4'd2; mac_heartbeat = 1'b1; link_fast = 1'b0;
        wr(5'h00, 32'h0000_0000);
        wait_done(0);
        repeat (3) @(negedge clk);
        chk("R8 no fetch/no line", 32'(fetch_n + line_n), 32'd0);
        rd(5'h00, v); chk("R8 zero size writeback", v, done_word(0, 0, 2, 1));
        chk("R8 irq on zero size", 32'(tok_irq), 32'd1);
        @(negedge clk); tok_ack = 1'b1; @(negedge clk); tok_ack = 1'b0;
    endtask

    task automatic t_backpressure(); // R12, R10, R4
        logic [31:0] v;
        clear_logs();
        line_ready = 1'b0;
        wr(5'h04, 32'h0000_0064);
        repeat (40) @(negedge clk);
        chk("R12 fetch stops at FIFO depth", 32'(fetch_n), 32'd16);
        chk("R12 no request when full", 32'(mem_req), 32'd0);
        wr(5'h04, 32'h0000_2004);
        wr(5'h14, 32'h0000_7000);
        rd(5'h04, v); chk("R10 in-service command write ignored", v, 32'h0000_0064);
        rd(5'h14, v); chk("R10 in-service base write ignored", v, 32'h0000_2000);
        @(negedge clk); line_ready = 1'b1;
        wait_done(1);
        chk_packet("R4 slot1 25 words", 32'h2000, 25, 0, 0);
        rd(5'h04, v); chk("R6 slot1 writeback", v, done_word(100, 0, 2, 1));
    endtask

    task automatic t_rewrite();  // R11
        logic [31:0] v;
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, v); chk("R11 rewrite clears result bits", v, 32'h003F_3FFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_rotation();
        t_threshold();
        t_zero();
        t_backpressure();
        t_rewrite();
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule